// File: doc/BRIEF.md
# Banked GPIO Port with Set/Clear Strobes

This block is a memory-mapped general-purpose I/O port built from up to five banks of 32 pins. Each bank owns a small group of word registers inside one byte-addressed register window, placed at a fixed stride. Software picks which pins drive by writing a per-bank direction word. In that word a one means input and a zero means output. Output levels change through three routes. The output latch can be written whole. A write-one-to-set register raises the chosen latch bits, and a write-one-to-clear register lowers them. The set and clear routes let a driver flip single pins without a read-modify-write.

Every pin level passes through a two-flop synchroniser before software can read it. The input word reports the pin whether or not that pin is being driven. A read that follows a change on the pins can return the old level for up to two clock edges. The bus is a plain 32-bit register port. Writes take effect on the clock edge that samples the write enable. Read data is combinational from the address.

Top module: `gpio_bank_port`

## Requirements
- R1: After reset every direction bit reads 1 and every latch bit is 0, so all output enables and all pin outputs are low.
- R2: A pin's output enable is high exactly when its direction bit is 0. The pin output always carries that pin's latch bit.
- R3: A write to a bank's set word (bank base +0x08) sets every latch bit whose data bit is 1 and leaves the other latch bits unchanged.
- R4: A write to a bank's clear word (bank base +0x0C) clears every latch bit whose data bit is 1 and leaves the other latch bits unchanged.
- R5: The output-data word (bank base +0x04) can be written directly. Reads of the output, set and clear words all return the current latch.
- R6: The input word (bank base +0x10) returns the pin levels through two synchroniser flops, so a change shows on the second rising edge after it. This holds for pins configured as outputs too.
- R7: Addresses outside the five words of an implemented bank read 0, and writes to them change no register and no pin. This covers window bytes 0x00-0x0F, bank words +0x14 to +0x24, misaligned addresses and space beyond the last bank.
- R8: Bank n's words start at window byte 0x10 + 0x28*n. A write to one bank touches only that bank's 32 pins.
- R9: The direction word (bank base +0x00) reads back the last value written to it and changes only when it is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address within the register window |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_out | output | NUM_BANKS*32 (160) | Per-pin output level |
| pin_oe | output | NUM_BANKS*32 (160) | Per-pin output enable, active high |
| pin_in | input | NUM_BANKS*32 (160) | Per-pin sampled level, asynchronous |

## Verification
The hardest case to reach is the synchroniser depth. The bus reads the input word combinationally, so the bench must catch the window in which the old level is still visible. The bench changes a bank's pins on a falling edge and then reads the input word after exactly one rising edge and again after the second. It expects the old value first and the new value second. It repeats this on a bank whose pins are driven as outputs, to show that reads follow the pins and not the latch.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int WORD_W    = 32;
  localparam int BANK_SPAN = 40;   // bytes between consecutive bank bases
  localparam int BANK_ORG  = 16;   // byte offset of bank 0
  localparam int NUM_REGS  = 5;    // implemented words per bank

  typedef enum logic [2:0] {
    REG_DIR = 3'd0,
    REG_OUT = 3'd1,
    REG_SET = 3'd2,
    REG_CLR = 3'd3,
    REG_IN  = 3'd4
  } reg_sel_t;

  function automatic int bank_base(input int bank);
    return BANK_ORG + BANK_SPAN * bank;
  endfunction

  function automatic logic [WORD_W-1:0] apply_set(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] mask);
    return cur | mask;
  endfunction

  function automatic logic [WORD_W-1:0] apply_clr(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] mask);
    return cur & ~mask;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int NUM_BANKS  = 5,
  parameter int ADDR_W     = 8,
  parameter int BANK_IDX_W = 3
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic                  hit,
  output logic [BANK_IDX_W-1:0] bank_idx,
  output reg_sel_t              reg_sel
);

  always_comb begin
    hit      = 1'b0;
    bank_idx = '0;
    reg_sel  = REG_DIR;
    for (int b = 0; b < NUM_BANKS; b++) begin
      int off;
      off = int'(addr) - bank_base(b);
      if (off >= 0 && off < BANK_SPAN && (off % 4) == 0 && (off / 4) < NUM_REGS) begin
        hit      = 1'b1;
        bank_idx = BANK_IDX_W'(b);
        reg_sel  = reg_sel_t'(3'(off / 4));
      end
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_out,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] in_q
);

  logic [W-1:0] sync1;
  logic [1:0]   sync_age;
  logic [W-1:0] latch_nxt;

  always_comb begin
    latch_nxt = latch_q;
    if (wr_out)      latch_nxt = wdata;
    else if (wr_set) latch_nxt = apply_set(latch_q, wdata);
    else if (wr_clr) latch_nxt = apply_clr(latch_q, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      latch_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      latch_q <= latch_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= '0;
      in_q     <= '0;
      sync_age <= '0;
    end else begin
      sync1 <= pins;
      in_q  <= sync1;
      if (sync_age != 2'd2) sync_age <= sync_age + 2'd1;
    end
  end

  // R3
  set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !wr_out) |=> ((latch_q & $past(wdata)) == $past(wdata)));

  // R4
  clr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_out && !wr_set) |=> ((latch_q & $past(wdata)) == '0));

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));

  // R6
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_age == 2'd2) |-> (in_q == $past(pins, 2)));

endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  output logic [NUM_BANKS*WORD_W-1:0] pin_out,
  output logic [NUM_BANKS*WORD_W-1:0] pin_oe,
  input  logic [NUM_BANKS*WORD_W-1:0] pin_in
);

  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic                  dec_hit;
  logic [BANK_IDX_W-1:0] dec_bank;
  reg_sel_t              dec_reg;

  logic [WORD_W-1:0] dir_w   [NUM_BANKS];
  logic [WORD_W-1:0] latch_w [NUM_BANKS];
  logic [WORD_W-1:0] in_w    [NUM_BANKS];

  gpio_addr_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .BANK_IDX_W(BANK_IDX_W)
  ) u_dec (
    .addr    (bus_addr),
    .hit     (dec_hit),
    .bank_idx(dec_bank),
    .reg_sel (dec_reg)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = bus_wr && dec_hit && (dec_bank == BANK_IDX_W'(b));

    gpio_bank #(.W(WORD_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_dir (sel && dec_reg == REG_DIR),
      .wr_out (sel && dec_reg == REG_OUT),
      .wr_set (sel && dec_reg == REG_SET),
      .wr_clr (sel && dec_reg == REG_CLR),
      .wdata  (bus_wdata),
      .pins   (pin_in[b*WORD_W +: WORD_W]),
      .dir_q  (dir_w[b]),
      .latch_q(latch_w[b]),
      .in_q   (in_w[b])
    );

    assign pin_out[b*WORD_W +: WORD_W] = latch_w[b];
    assign pin_oe [b*WORD_W +: WORD_W] = ~dir_w[b];
  end

  always_comb begin
    bus_rdata = '0;
    if (dec_hit) begin
      unique case (dec_reg)
        REG_DIR:                   bus_rdata = dir_w[dec_bank];
        REG_OUT, REG_SET, REG_CLR: bus_rdata = latch_w[dec_bank];
        REG_IN:                    bus_rdata = in_w[dec_bank];
        default:                   bus_rdata = '0;
      endcase
    end
  end

  // R7
  unused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> (bus_rdata == '0));

  // R2
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dec_hit && dec_reg == REG_DIR && dec_bank == '0)
      |=> (pin_oe[WORD_W-1:0] == ~$past(bus_wdata)));

endmodule

// File: tb/gpio_bank_port_bench.sv
module gpio_bank_port_bench;
  localparam int NB = 5;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NP-1:0] pin_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank_port u_gpio_bank_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
  );

  // {write, addr, data}: write rows store data, read rows expect data
  localparam int NV = 18;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h10, 32'h0000_FFFF},  // R9 dir write bank0
    {1'b0, 8'h10, 32'h0000_FFFF},  // R9
    {1'b1, 8'h18, 32'h0000_00F0},  // R3 set
    {1'b0, 8'h14, 32'h0000_00F0},  // R3 R5
    {1'b1, 8'h1C, 32'h0000_0030},  // R4 clear
    {1'b0, 8'h18, 32'h0000_00C0},  // R4 R5 set word reads latch
    {1'b1, 8'h14, 32'hA5A5_0000},  // R5 direct write
    {1'b0, 8'h1C, 32'hA5A5_0000},  // R5 clear word reads latch
    {1'b1, 8'h18, 32'h0000_0001},  // R3 set on top of direct value
    {1'b0, 8'h14, 32'hA5A5_0001},  // R3
    {1'b1, 8'h40, 32'h8000_0001},  // R8 bank1 set
    {1'b0, 8'h3C, 32'h8000_0001},  // R8
    {1'b0, 8'h14, 32'hA5A5_0001},  // R8 bank0 untouched
    {1'b1, 8'h00, 32'hFFFF_FFFF},  // R7 unused write
    {1'b1, 8'h24, 32'hFFFF_FFFF},  // R7 bank0 +0x14 unused
    {1'b0, 8'h24, 32'h0000_0000},  // R7
    {1'b0, 8'h00, 32'h0000_0000},  // R7
    {1'b0, 8'h10, 32'h0000_FFFF}   // R7 dir unchanged after unused writes
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(8'h10, rd); check("R1 dir bank0", rd, 32'hFFFF_FFFF);
    bus_read(8'hB0, rd); check("R1 dir bank4", rd, 32'hFFFF_FFFF);
    bus_read(8'hB4, rd); check("R1 latch bank4", rd, 32'h0);
    check("R1 pin_oe", 32'(pin_oe != '0), 32'h0);
    check("R1 pin_out", 32'(pin_out != '0), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) bus_write(VEC[i][39:32], VEC[i][31:0]);
      else begin
        @(negedge clk);
        bus_read(VEC[i][39:32], rd);
        check($sformatf("vector %0d", i), rd, VEC[i][31:0]);
      end
    end

    // R2 pins follow direction and latch
    @(negedge clk); #1;
    check("R2 oe bank0", pin_oe[31:0], 32'hFFFF_0000);
    check("R2 out bank0", pin_out[31:0], 32'hA5A5_0001);
    check("R8 out bank1", pin_out[63:32], 32'h8000_0001);
    check("R7 R8 bank2..4 quiet", 32'(pin_out[NP-1:64] != '0), 32'h0);

    // R8 bank4 decode at top of window
    bus_write(8'hB0, 32'h0F0F_0F0F);
    @(negedge clk); #1;
    check("R8 oe bank4", pin_oe[159:128], 32'hF0F0_F0F0);
    check("R8 oe bank0 kept", pin_oe[31:0], 32'hFFFF_0000);
    bus_read(8'hD8, rd); check("R7 beyond last bank", rd, 32'h0);
    bus_read(8'h11, rd); check("R7 misaligned", rd, 32'h0);

    // R6 synchroniser depth on bank2 input pins
    @(negedge clk);
    pin_in[95:64] = 32'hCAFE_F00D;
    bus_addr = 8'h70;
    @(negedge clk); bus_read(8'h70, rd); check("R6 one edge old", rd, 32'h0);
    @(negedge clk); bus_read(8'h70, rd); check("R6 two edges new", rd, 32'hCAFE_F00D);

    // R6 input word follows pins on an output-configured bank
    bus_write(8'h10, 32'h0);
    @(negedge clk);
    pin_in[31:0] = 32'h1234_5678;
    @(negedge clk); bus_read(8'h20, rd); check("R6 output pin old", rd, 32'h0);
    @(negedge clk); bus_read(8'h20, rd); check("R6 output pin read", rd, 32'h1234_5678);
    check("R2 all outputs", pin_oe[31:0], 32'hFFFF_FFFF);

    // R4 clear leaves unmasked bits
    bus_write(8'h1C, 32'hFFFF_0000);
    @(negedge clk); #1;
    check("R4 clear upper", pin_out[31:0], 32'h0000_0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule